// File: doc/BRIEF.md
# Supply-Monitor Path Self-Test Sequencer

This block checks the fault-detection paths of a device's internal supply monitors. It does not check the supplies themselves. A run starts when the host issues a start command. The block then visits thirteen monitor paths, one after another. For each path it raises that path's force line, which makes the comparator report a fault. The block then looks for two responses from the path: the trigger into the fault-flag register and the trigger toward the external alert pin.

A path counts as healthy only if both triggers appear inside a fixed settle window. When a path fails, the run keeps going and every later path is still visited. After each path, a one-cycle clear step wipes the latched flags and the alert latch, so the next path starts clean.

The host can ask to keep the flags instead of clearing them after each path. After such a run, the flag vector shows which paths managed to raise their register trigger, so the host can locate a dead path. Three paths belong to an optional auxiliary reference. While that reference is off, their results never count against the run. At the end of a run, a sticky self-test-fail flag reports whether any counted path failed.

Top module: `supmon_selftest`

## Requirements
- R1: After reset, busy, done, every force line, every flag, the self-test-fail flag and the alert output are all 0.
- R2: A start command accepted while idle begins a run. In that run the paths are forced one at a time, in index order 0 to 12, with at most one force bit high at once. Each path's force line is held for exactly 8 cycles. Bit i of the force, trigger and flag vectors belongs to path i.
- R3: Between two consecutive paths there is exactly one cycle with all force lines low. This is the clear step.
- R4: A path passes only if its register trigger and its pin trigger are both seen while that path is forced. If either trigger is missing, the self-test-fail flag is set at the end of the run.
- R5: A trigger counts only if it arrives by the 8th forced cycle. A trigger that first appears on the 8th forced cycle still passes; one that would first appear on the 9th counts as missing.
- R6: A failing path does not end the run. All 13 paths are forced in every run, and done follows the start edge by exactly 117 cycles (13 × (8 + 1)).
- R7: While the auxiliary-reference enable (sampled at start) is 0, failures on paths 8, 9 and 10 do not set the self-test-fail flag. Failures on the other paths still do. While the enable is 1, failures on paths 8, 9 and 10 count like any other path.
- R8: Unless keep-flags (sampled at start) is set, every clear step zeroes the flag vector and the alert latch, so both are 0 after the run. With keep-flags set, nothing is cleared during the run. Afterwards, flag i is 1 exactly for the paths whose register trigger fired.
- R9: Alert is 1 only when the alert latch is set and the pin enable is 1. The alert latch is set by any pin trigger. With the pin enable at 0, alert stays 0 for the whole run. With the pin enable at 1 on a healthy run, alert rises once per path.
- R10: Busy is 1 from the start edge until the run ends. Done is a single-cycle pulse in the first cycle after the run, with busy already 0. The self-test-fail flag changes only at that point, or when it is reset to 0 at the start of a new run, and otherwise holds its value.
- R11: A start command issued while busy is ignored. The run in progress keeps its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Start command, one-cycle strobe from the host write |
| no_clear_i | input | 1 | Keep-flags option: skip the per-path clear step |
| aux_en_i | input | 1 | Auxiliary reference enabled; when 0, paths 8 to 10 are not counted |
| pin_en_i | input | 1 | Alert pin output enable |
| reg_trig_i | input | 13 | Per-path fault-register trigger from the monitors |
| pin_trig_i | input | 13 | Per-path alert-pin trigger from the monitors |
| force_o | output | 13 | Per-path force line into the monitor comparators |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse at end of run |
| flags_o | output | 13 | Latched per-path fault flags |
| bist_fail_o | output | 1 | Sticky self-test-fail flag |
| alert_o | output | 1 | Alert pin output, gated by pin enable |

## Verification
The hardest case to reach is a trigger that lands right at the edge of the settle window. Inside the block, a path is judged on its last forced cycle, and the outcome only shows up about a hundred cycles later in the fail flag. The bench uses a monitor model that raises each trigger a programmable number of forced cycles after the force line rises. With that model it can place the first trigger on the 8th forced cycle, which must pass, or on the 9th, which must fail. Another check isolates the gating of the auxiliary paths: it breaks a single path and reads back the result both with the auxiliary reference on and with it off.

// File: rtl/supmon_selftest_pkg.sv
package supmon_selftest_pkg;

    // Sequencer phase
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FORCE = 2'd1,
        ST_CLEAR = 2'd2
    } seq_state_e;

    // Default geometry of the path set
    localparam int unsigned DEF_NPATH    = 13;
    localparam int unsigned DEF_WIN      = 8;
    localparam logic [12:0] DEF_AUX_MASK = 13'h0700;

endpackage

// File: rtl/supmon_selftest_seq.sv
module supmon_selftest_seq
    import supmon_selftest_pkg::*;
#(
    parameter int unsigned          NPATH    = DEF_NPATH,
    parameter int unsigned          WIN      = DEF_WIN,
    parameter logic [NPATH-1:0]     AUX_MASK = DEF_AUX_MASK,
    localparam int unsigned         IW       = (NPATH > 1) ? $clog2(NPATH) : 1,
    localparam int unsigned         CW       = (WIN > 1) ? $clog2(WIN) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             go_i,
    input  logic             no_clear_i,
    input  logic             aux_en_i,
    input  logic [NPATH-1:0] reg_trig_i,
    input  logic [NPATH-1:0] pin_trig_i,
    output logic             active_o,
    output logic [IW-1:0]    idx_o,
    output logic             start_o,
    output logic             clr_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             bist_fail_o
);

    localparam logic [IW-1:0] LAST_IDX = IW'(NPATH - 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(WIN - 1);

    typedef struct packed {
        seq_state_e    st;
        logic [IW-1:0] idx;
        logic [CW-1:0] cnt;
        logic          seen_reg;
        logic          seen_pin;
        logic          fail_acc;
        logic          bist_fail;
        logic          done;
        logic          keep;
        logic          aux_on;
    } seq_s;

    seq_s s_d, s_q;
    logic start_d, clr_d;
    logic hit_reg, hit_pin, counted;

    always_comb begin
        s_d     = s_q;
        s_d.done = 1'b0;
        start_d = 1'b0;
        clr_d   = 1'b0;
        hit_reg = s_q.seen_reg | reg_trig_i[s_q.idx];
        hit_pin = s_q.seen_pin | pin_trig_i[s_q.idx];
        counted = !AUX_MASK[s_q.idx] || s_q.aux_on;

        unique case (s_q.st)
            ST_IDLE: begin
                if (go_i) begin
                    start_d       = 1'b1;
                    s_d.st        = ST_FORCE;
                    s_d.idx       = '0;
                    s_d.cnt       = '0;
                    s_d.seen_reg  = 1'b0;
                    s_d.seen_pin  = 1'b0;
                    s_d.fail_acc  = 1'b0;
                    s_d.bist_fail = 1'b0;
                    s_d.keep      = no_clear_i;
                    s_d.aux_on    = aux_en_i;
                end
            end
            ST_FORCE: begin
                s_d.seen_reg = hit_reg;
                s_d.seen_pin = hit_pin;
                if (s_q.cnt == LAST_CNT) begin
                    s_d.st  = ST_CLEAR;
                    s_d.cnt = '0;
                    if (!(hit_reg && hit_pin) && counted) begin
                        s_d.fail_acc = 1'b1;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + CW'(1);
                end
            end
            ST_CLEAR: begin
                clr_d        = !s_q.keep;
                s_d.seen_reg = 1'b0;
                s_d.seen_pin = 1'b0;
                if (s_q.idx == LAST_IDX) begin
                    s_d.st        = ST_IDLE;
                    s_d.done      = 1'b1;
                    s_d.bist_fail = s_q.fail_acc;
                end else begin
                    s_d.idx = s_q.idx + IW'(1);
                    s_d.st  = ST_FORCE;
                end
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{st: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign active_o    = (s_q.st == ST_FORCE);
    assign idx_o       = s_q.idx;
    assign start_o     = start_d;
    assign clr_o       = clr_d;
    assign busy_o      = (s_q.st != ST_IDLE);
    assign done_o      = s_q.done;
    assign bist_fail_o = s_q.bist_fail;

endmodule

// File: rtl/supmon_selftest_force.sv
module supmon_selftest_force #(
    parameter int unsigned  NPATH = 13,
    localparam int unsigned IW    = (NPATH > 1) ? $clog2(NPATH) : 1
) (
    input  logic             active_i,
    input  logic [IW-1:0]    idx_i,
    output logic [NPATH-1:0] force_o
);

    // One decoded force line per monitor path
    for (genvar g = 0; g < NPATH; g++) begin : g_force
        assign force_o[g] = active_i && (idx_i == IW'(g));
    end

endmodule

// File: rtl/supmon_selftest_latch.sv
module supmon_selftest_latch #(
    parameter int unsigned NPATH = 13
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NPATH-1:0] reg_trig_i,
    input  logic [NPATH-1:0] pin_trig_i,
    input  logic             clr_i,
    input  logic             start_i,
    input  logic             pin_en_i,
    output logic [NPATH-1:0] flags_o,
    output logic             alert_o
);

    typedef struct packed {
        logic [NPATH-1:0] flags;
        logic             alert;
    } lat_s;

    lat_s l_d, l_q;

    always_comb begin
        l_d       = l_q;
        l_d.flags = l_q.flags | reg_trig_i;
        l_d.alert = l_q.alert | (|pin_trig_i);
        // Clearing wins over a same-cycle trigger
        if (clr_i || start_i) begin
            l_d.flags = '0;
            l_d.alert = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            l_q <= '0;
        end else begin
            l_q <= l_d;
        end
    end

    assign flags_o = l_q.flags;
    assign alert_o = l_q.alert & pin_en_i;

endmodule

// File: rtl/supmon_selftest.sv
module supmon_selftest
    import supmon_selftest_pkg::*;
#(
    parameter int unsigned      NPATH    = DEF_NPATH,
    parameter int unsigned      WIN      = DEF_WIN,
    parameter logic [NPATH-1:0] AUX_MASK = DEF_AUX_MASK
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             go_i,
    input  logic             no_clear_i,
    input  logic             aux_en_i,
    input  logic             pin_en_i,
    input  logic [NPATH-1:0] reg_trig_i,
    input  logic [NPATH-1:0] pin_trig_i,
    output logic [NPATH-1:0] force_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [NPATH-1:0] flags_o,
    output logic             bist_fail_o,
    output logic             alert_o
);

    localparam int unsigned IW = (NPATH > 1) ? $clog2(NPATH) : 1;

    logic          active;
    logic [IW-1:0] idx;
    logic          start_pulse;
    logic          clr_pulse;

    supmon_selftest_seq #(
        .NPATH   (NPATH),
        .WIN     (WIN),
        .AUX_MASK(AUX_MASK)
    ) seq_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .go_i       (go_i),
        .no_clear_i (no_clear_i),
        .aux_en_i   (aux_en_i),
        .reg_trig_i (reg_trig_i),
        .pin_trig_i (pin_trig_i),
        .active_o   (active),
        .idx_o      (idx),
        .start_o    (start_pulse),
        .clr_o      (clr_pulse),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .bist_fail_o(bist_fail_o)
    );

    supmon_selftest_force #(
        .NPATH(NPATH)
    ) force_i (
        .active_i(active),
        .idx_i   (idx),
        .force_o (force_o)
    );

    supmon_selftest_latch #(
        .NPATH(NPATH)
    ) latch_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .reg_trig_i(reg_trig_i),
        .pin_trig_i(pin_trig_i),
        .clr_i     (clr_pulse),
        .start_i   (start_pulse),
        .pin_en_i  (pin_en_i),
        .flags_o   (flags_o),
        .alert_o   (alert_o)
    );

endmodule

// File: rtl/supmon_selftest_chk.sv
module supmon_selftest_chk #(
    parameter int unsigned NPATH = 13
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             go_i,
    input logic             pin_en_i,
    input logic [NPATH-1:0] force_o,
    input logic             busy_o,
    input logic             done_o,
    input logic             bist_fail_o,
    input logic             alert_o
);

    assert_force_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(force_o));

    assert_force_in_run_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (force_o != '0) |-> busy_o);

    assert_force_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (force_o != '0) |=> ((force_o == '0) || (force_o == $past(force_o))));

    assert_alert_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pin_en_i |-> !alert_o);

    assert_done_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);

    assert_fail_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(bist_fail_o) |-> (done_o || $rose(busy_o)));

    assert_go_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && go_i && (force_o != '0)) |=> busy_o);

endmodule

bind supmon_selftest supmon_selftest_chk #(
    .NPATH(NPATH)
) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (go_i),
    .pin_en_i   (pin_en_i),
    .force_o    (force_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .bist_fail_o(bist_fail_o),
    .alert_o    (alert_o)
);

// File: tb/supmon_selftest_tb_top.sv
`timescale 1ns/1ps
module supmon_selftest_tb_top;

    localparam int NP = 13;
    localparam int RUN_LEN = 117;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          go = 1'b0;
    logic          no_clear = 1'b0;
    logic          aux_en = 1'b1;
    logic          pin_en = 1'b1;
    logic [NP-1:0] reg_trig = '0;
    logic [NP-1:0] pin_trig = '0;
    logic [NP-1:0] force_o;
    logic          busy, done, bist_fail, alert;
    logic [NP-1:0] flags;

    always #2.5 clk = ~clk;

    supmon_selftest dut_i (
        .clk_i(clk), .rst_ni(rst_n), .go_i(go), .no_clear_i(no_clear),
        .aux_en_i(aux_en), .pin_en_i(pin_en), .reg_trig_i(reg_trig),
        .pin_trig_i(pin_trig), .force_o(force_o), .busy_o(busy),
        .done_o(done), .flags_o(flags), .bist_fail_o(bist_fail),
        .alert_o(alert)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // Monitor model: per-path health masks and trigger delays
    logic [NP-1:0] reg_ok = '1;
    logic [NP-1:0] pin_ok = '1;
    int reg_delay = 0;
    int pin_delay = 0;
    int fcnt [NP];

    always @(negedge clk) begin
        for (int i = 0; i < NP; i++) begin
            fcnt[i] = force_o[i] ? fcnt[i] + 1 : 0;
            reg_trig[i] = force_o[i] && reg_ok[i] && (fcnt[i] > reg_delay);
            pin_trig[i] = force_o[i] && pin_ok[i] && (fcnt[i] > pin_delay);
        end
    end

    // Run observer
    int ord [16];
    int ord_n, gap_err, multi_err, alert_rises;
    int fcyc [NP];
    logic [NP-1:0] prev_force = '0;
    logic prev_alert = 1'b0;

    always @(negedge clk) begin
        if (force_o != '0) begin
            if ($countones(force_o) > 1) multi_err++;
            if (prev_force != '0 && prev_force != force_o) gap_err++;
            for (int i = 0; i < NP; i++) begin
                if (force_o[i]) begin
                    fcyc[i]++;
                    if (force_o != prev_force && ord_n < 16) begin
                        ord[ord_n] = i;
                        ord_n++;
                    end
                end
            end
        end
        if (alert && !prev_alert) alert_rises++;
        prev_force = force_o;
        prev_alert = alert;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    int run_cycles;
    bit busy_mid, done_next;

    task automatic do_run(input bit mid_go);
        ord_n = 0; gap_err = 0; multi_err = 0; alert_rises = 0;
        for (int i = 0; i < NP; i++) fcyc[i] = 0;
        busy_mid = 1'b0;
        @(negedge clk); go = 1'b1;
        @(negedge clk); go = 1'b0;
        run_cycles = 0;
        while (!done && run_cycles < 1000) begin
            @(negedge clk);
            run_cycles++;
            if (run_cycles == 50) busy_mid = busy;
            if (mid_go && run_cycles == 30) go = 1'b1;
            if (mid_go && run_cycles == 31) go = 1'b0;
        end
        @(negedge clk);
        done_next = done;
    endtask

    function automatic bit order_ok();
        if (ord_n != NP) return 1'b0;
        for (int k = 0; k < NP; k++) if (ord[k] != k) return 1'b0;
        return 1'b1;
    endfunction

    task automatic set_model(input logic [NP-1:0] rok, input logic [NP-1:0] pok,
                             input int rd, input int pd);
        reg_ok = rok; pin_ok = pok; reg_delay = rd; pin_delay = pd;
    endtask

    task automatic t_reset();
        check(busy == 0 && done == 0, "R1", "busy/done after reset", {busy, done}, 0);
        check(force_o == '0, "R1", "force after reset", force_o, 0);
        check(flags == '0 && bist_fail == 0 && alert == 0, "R1",
              "flags/fail/alert after reset", {flags, bist_fail, alert}, 0);
    endtask

    task automatic t_healthy();
        no_clear = 0; aux_en = 1; pin_en = 1;
        set_model('1, '1, 0, 0);
        do_run(1'b0);
        check(run_cycles == RUN_LEN, "R6", "run length", run_cycles, RUN_LEN);
        check(order_ok(), "R2", "force order 0..12", ord_n, NP);
        for (int i = 0; i < NP; i++)
            check(fcyc[i] == 8, "R2", $sformatf("force cycles path %0d", i), fcyc[i], 8);
        check(multi_err == 0, "R2", "one force at a time", multi_err, 0);
        check(gap_err == 0, "R3", "idle cycle between paths", gap_err, 0);
        check(bist_fail == 0, "R4", "healthy run fail flag", bist_fail, 0);
        check(flags == '0 && alert == 0, "R8", "flags cleared after run", flags, 0);
        check(alert_rises == NP, "R9", "alert toggles per path", alert_rises, NP);
        check(busy_mid == 1, "R10", "busy during run", busy_mid, 1);
        check(done_next == 0, "R10", "done one cycle wide", done_next, 0);
    endtask

    task automatic t_reg_missing();
        set_model(~13'h0008, '1, 0, 0);
        do_run(1'b0);
        check(bist_fail == 1, "R4", "missing register trigger path 3", bist_fail, 1);
        check(ord_n == NP && run_cycles == RUN_LEN, "R6", "no abort after failure", ord_n, NP);
    endtask

    task automatic t_pin_missing();
        set_model('1, ~13'h1000, 0, 0);
        do_run(1'b0);
        check(bist_fail == 1, "R4", "missing pin trigger path 12", bist_fail, 1);
    endtask

    task automatic t_window_edge();
        set_model('1, '1, 7, 7);
        do_run(1'b0);
        check(bist_fail == 0, "R5", "trigger on last window cycle", bist_fail, 0);
        set_model('1, '1, 0, 8);
        do_run(1'b0);
        check(bist_fail == 1, "R5", "trigger after window", bist_fail, 1);
    endtask

    task automatic t_aux();
        aux_en = 0;
        set_model(~13'h0200, '1, 0, 0);
        do_run(1'b0);
        check(bist_fail == 0, "R7", "aux path ignored when off", bist_fail, 0);
        set_model('1, ~13'h0004, 0, 0);
        do_run(1'b0);
        check(bist_fail == 1, "R7", "normal path counted when aux off", bist_fail, 1);
        aux_en = 1;
        set_model(~13'h0200, '1, 0, 0);
        do_run(1'b0);
        check(bist_fail == 1, "R7", "aux path counted when on", bist_fail, 1);
    endtask

    task automatic t_keep_flags();
        no_clear = 1;
        set_model(~13'h0020, '1, 0, 0);
        do_run(1'b0);
        check(flags == ~13'h0020, "R8", "kept flags show dead path 5", flags, ~13'h0020);
        check(alert == 1, "R9", "alert latched with keep-flags", alert, 1);
        check(bist_fail == 1, "R4", "keep-flags run fails", bist_fail, 1);
        no_clear = 0;
    endtask

    task automatic t_pin_off();
        pin_en = 0;
        set_model('1, '1, 0, 0);
        do_run(1'b0);
        check(alert_rises == 0, "R9", "alert silent when pin disabled", alert_rises, 0);
        check(bist_fail == 0, "R9", "pin disable does not fail run", bist_fail, 0);
        pin_en = 1;
    endtask

    task automatic t_sticky();
        set_model(~13'h0001, '1, 0, 0);
        do_run(1'b0);
        repeat (20) @(negedge clk);
        check(bist_fail == 1, "R10", "fail flag held while idle", bist_fail, 1);
        set_model('1, '1, 0, 0);
        @(negedge clk); go = 1'b1;
        @(negedge clk); go = 1'b0;
        check(bist_fail == 0, "R10", "fail flag reset at new start", bist_fail, 0);
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_go_busy();
        set_model('1, '1, 0, 0);
        do_run(1'b1);
        check(run_cycles == RUN_LEN, "R11", "start while busy ignored", run_cycles, RUN_LEN);
        check(order_ok(), "R11", "order intact after busy start", ord_n, NP);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_healthy();
        t_reg_missing();
        t_pin_missing();
        t_window_edge();
        t_aux();
        t_keep_flags();
        t_pin_off();
        t_sticky();
        t_go_busy();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule